// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a byte-oriented asynchronous serial port with three frame modes, chosen by a two-bit mode field. One mode carries eight data bits and runs at a rate set by an external baud tick. A second carries nine bits at a fixed rate derived from the core clock. A third carries nine bits at the externally set rate. The ninth bit is written by software on transmit and reported back on receive, so it can serve as a parity bit, an extra data bit or an address marker for multiprocessor links.

Software starts a transmission by writing a byte. It learns that the stop bit has begun from a transmit flag that it must clear itself. Received frames are stored only when the previous frame has been taken and the receive flag cleared. When the address filter is on, a frame is also stored only if its filter bit is 1. Any other frame is dropped without trace. The receiver oversamples each bit sixteen times and decides each bit by a majority of the three middle samples.

Top module: `mpuart`

## Requirements
- R1: The mode field selects the frame: 01 gives 8 data bits at the external rate, 10 gives 9 bits at the fixed rate, and 11 gives 9 bits at the external rate. With 00 a write does not start a transmission (txd stays 1, tx_flag stays 0) and no frame is received.
- R2: In mode 01 a transmitted frame is a 0 start bit, then the eight bits of tx_data with bit 0 first, then a 1 stop bit.
- R3: In modes 10 and 11 a transmitted frame is a 0 start bit, then the eight data bits with bit 0 first, then the tx_bit9 value captured at the write, then a 1 stop bit.
- R4: txd idles at 1. After a write, the start bit begins at the next bit boundary, within one bit period. A write made while a frame is pending or being sent is ignored and produces no further frame.
- R5: tx_flag goes to 1 when the stop bit starts on txd. It stays 1 until a tx_flag_clr pulse.
- R6: In mode 10 one bit lasts FIX_DIV clock cycles (64 by default), or FIX_DIV/2 cycles when dbl_speed is 1.
- R7: In modes 01 and 11 one bit lasts OVS (16) baud_tick pulses.
- R8: Reception starts only on a 1-to-0 edge of rxd while rx_en is 1. Each bit is the majority of samples 7, 8 and 9 of the 16 taken in its period. A start bit that is not low at its middle is rejected, and the receiver waits for a new edge.
- R9: At the last received bit the frame is stored, with rx_data taking the byte and rx_flag set to 1, only if rx_flag is 0 and either mp_filter is 0 or the filter bit is 1. Otherwise rx_data, rx_bit9 and rx_flag stay unchanged.
- R10: On store, rx_bit9 takes the stop bit in mode 01 and the ninth bit in modes 10 and 11. That same bit is the filter bit of R9.
- R11: rx_flag stays 1 until a rx_flag_clr pulse. Reset gives txd = 1, both flags 0, rx_data = 0 and rx_bit9 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Frame mode: 01, 10, 11; 00 is inert |
| dbl_speed | input | 1 | Halves the fixed-rate bit period |
| baud_tick | input | 1 | One pulse per sample (16 per bit) for modes 01 and 11 |
| tx_wr | input | 1 | Write strobe for the transmit byte |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in the 9-bit modes |
| txd | output | 1 | Serial transmit line |
| tx_flag | output | 1 | Stop bit has started |
| tx_flag_clr | input | 1 | Clears tx_flag |
| rxd | input | 1 | Serial receive line |
| rx_en | input | 1 | Allows new receptions to start |
| mp_filter | input | 1 | Stores only frames whose filter bit is 1 |
| rx_data | output | 8 | Last stored byte |
| rx_bit9 | output | 1 | Ninth or stop bit of the last stored frame |
| rx_flag | output | 1 | A frame has been stored |
| rx_flag_clr | input | 1 | Clears rx_flag |

## Verification
The bench builds the port with its default FIX_DIV of 64 and OVS of 16. It runs baud_tick at one pulse every five cycles, which makes the external-rate bit 80 cycles, distinct from both fixed-rate periods of 64 and 32. A wrong divider or a wrong mode decode therefore shows up as a wrong start-bit width or a misframed byte. Short bits keep full frames cheap, so the bench can try filter-bit combinations, a frame that lands on a full receive buffer, a rejected start glitch and an ignored write within one short run.

// File: rtl/mpuart.sv
module mpuart #(
  parameter int FIX_DIV = 64,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       dbl_speed,
  input  logic       baud_tick,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_bit9,
  output logic       txd,
  output logic       tx_flag,
  input  logic       tx_flag_clr,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       mp_filter,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_flag,
  input  logic       rx_flag_clr
);

  localparam int STEP = FIX_DIV / OVS;
  localparam int PW   = $clog2(STEP + 1);
  localparam int SW   = $clog2(OVS);
  localparam int MID  = OVS / 2;

  logic [PW-1:0] pre;
  wire  [PW-1:0] pre_top  = dbl_speed ? PW'(STEP / 2 - 1) : PW'(STEP - 1);
  wire           fix_tick = (pre >= pre_top);
  wire           tick     = (mode_sel == 2'b10) ? fix_tick : baud_tick;
  wire           mode_on  = (mode_sel != 2'b00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre <= '0;
    else if (fix_tick) pre <= '0;
    else               pre <= pre + PW'(1);

  logic [SW-1:0] tx_div;
  logic          tx_pend, tx_act, tx_nine;
  logic [10:0]   tx_sh;
  logic [3:0]    tx_left;

  wire bnd       = tick && (tx_div == SW'(OVS - 1));
  wire tx_accept = tx_wr && !tx_pend && !tx_act && mode_on;
  wire tx_set    = bnd && tx_act && (tx_left == 4'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    tx_div <= '0;
    else if (tick) tx_div <= (tx_div == SW'(OVS - 1)) ? '0 : tx_div + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend <= 1'b0;
      tx_act  <= 1'b0;
      tx_nine <= 1'b0;
      tx_sh   <= '1;
      tx_left <= '0;
      txd     <= 1'b1;
    end else if (tx_pend) begin
      if (bnd) begin
        txd     <= tx_sh[0];
        tx_sh   <= {1'b1, tx_sh[10:1]};
        tx_left <= tx_nine ? 4'd10 : 4'd9;
        tx_act  <= 1'b1;
        tx_pend <= 1'b0;
      end
    end else if (tx_act) begin
      if (bnd) begin
        if (tx_left == 4'd0) begin
          tx_act <= 1'b0;
          txd    <= 1'b1;
        end else begin
          txd     <= tx_sh[0];
          tx_sh   <= {1'b1, tx_sh[10:1]};
          tx_left <= tx_left - 4'd1;
        end
      end
    end else if (tx_accept) begin
      tx_sh   <= {1'b1, (mode_sel == 2'b01) ? 1'b1 : tx_bit9, tx_data, 1'b0};
      tx_nine <= (mode_sel != 2'b01);
      tx_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           tx_flag <= 1'b0;
    else if (tx_set)      tx_flag <= 1'b1;
    else if (tx_flag_clr) tx_flag <= 1'b0;

  logic          rx_s1, rx_s2, rx_prev, rx_act, smp_a, smp_b;
  logic [SW-1:0] rx_ph;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;

  wire vote      = (smp_a & smp_b) | (smp_a & rx_s2) | (smp_b & rx_s2);
  wire start_det = rx_prev && !rx_s2 && rx_en && mode_on && !rx_act;
  wire decide    = rx_act && tick && (rx_ph == SW'(MID + 1));
  wire store     = decide && (rx_idx == 4'd9) && !rx_flag && (!mp_filter || vote);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s1, rx_s2, rx_prev} <= 3'b111;
    else        {rx_s1, rx_s2, rx_prev} <= {rxd, rx_s1, rx_s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0;
      rx_ph  <= '0;
      rx_idx <= '0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      rx_sh  <= '0;
    end else if (!rx_act) begin
      if (start_det) begin
        rx_act <= 1'b1;
        rx_ph  <= '0;
        rx_idx <= '0;
      end
    end else if (tick) begin
      if (rx_ph == SW'(OVS - 1)) begin
        rx_ph  <= '0;
        rx_idx <= rx_idx + 4'd1;
      end else begin
        rx_ph <= rx_ph + SW'(1);
      end
      if (rx_ph == SW'(MID - 1)) smp_a <= rx_s2;
      if (rx_ph == SW'(MID))     smp_b <= rx_s2;
      if (decide) begin
        if (rx_idx == 4'd0)      rx_act <= !vote;
        else if (rx_idx == 4'd9) rx_act <= 1'b0;
        else                     rx_sh  <= {vote, rx_sh[7:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_flag <= 1'b0;
    end else if (store) begin
      rx_data <= rx_sh;
      rx_bit9 <= vote;
      rx_flag <= 1'b1;
    end else if (rx_flag_clr) begin
      rx_flag <= 1'b0;
    end

  // R5
  tx_flag_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> txd);

  // R5
  tx_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flag && !tx_flag_clr |=> tx_flag);

  // R4
  tx_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_act |=> !tx_pend);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rx_flag_clr |=> $stable(rx_data) && $stable(rx_bit9));

  // R10
  rx_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && $past(mp_filter) |-> rx_bit9);

  // R11
  rx_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rx_flag_clr |=> rx_flag);

  // R1
  rx_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) && !rx_act |=> !rx_act);

endmodule

// File: tb/test_mpuart.sv
module test_mpuart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic       dbl_speed = 1'b0, baud_tick = 1'b0;
  logic       tx_wr = 1'b0, tx_bit9 = 1'b0, tx_flag_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rxd = 1'b1, rx_en = 1'b1, mp_filter = 1'b0, rx_flag_clr = 1'b0;
  logic       txd, tx_flag, rx_bit9, rx_flag;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  logic [7:0] m_data = 8'h00;
  logic       m_b9 = 1'b0, m_flag = 1'b0;

  localparam int VPER = 80;

  always #2 clk = ~clk;

  mpuart i_mpuart (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dbl_speed(dbl_speed),
    .baud_tick(baud_tick), .tx_wr(tx_wr), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .txd(txd), .tx_flag(tx_flag), .tx_flag_clr(tx_flag_clr), .rxd(rxd),
    .rx_en(rx_en), .mp_filter(mp_filter), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .rx_flag_clr(rx_flag_clr)
  );

  initial forever begin
    repeat (4) @(negedge clk);
    baud_tick = 1'b1;
    @(negedge clk);
    baud_tick = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d, input logic b9);
    @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic clear_tx();
    @(negedge clk) tx_flag_clr = 1'b1;
    @(negedge clk) tx_flag_clr = 1'b0;
    chk(tx_flag == 1'b0, "R5", "tx_flag after clear", int'(tx_flag), 0);
  endtask

  task automatic clear_rx();
    @(negedge clk) rx_flag_clr = 1'b1;
    @(negedge clk) rx_flag_clr = 1'b0;
    m_flag = 1'b0;
    chk(rx_flag == 1'b0, "R11", "rx_flag after clear", int'(rx_flag), 0);
  endtask

  task automatic tx_frame(input logic [1:0] m, input logic dbl, input logic [7:0] d,
                          input logic b9, input int per, input bit poke, input string req);
    int cnt;
    int lows;
    logic [7:0] got;
    logic gb9;
    mode_sel = m; dbl_speed = dbl;
    write_byte(d, b9);
    cnt = 0;
    while (txd === 1'b1 && cnt < 3 * per) begin
      @(negedge clk); cnt++;
    end
    chk(cnt > 0 && cnt <= per + 2, "R4", "cycles from write to start bit", cnt, per);
    wait_n(per / 2);
    chk(txd == 1'b0, req, "start bit", int'(txd), 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      wait_n(per);
      got[i] = txd;
      if (poke && i == 3) begin
        @(negedge clk) begin tx_data = 8'h00; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
        wait_n(per - 2);
        i++;
        got[i] = txd;
      end
    end
    chk(got == d, req, "data bits", int'(got), int'(d));
    if (m != 2'b01) begin
      wait_n(per);
      gb9 = txd;
      chk(gb9 == b9, "R3", "ninth bit", int'(gb9), int'(b9));
    end
    chk(tx_flag == 1'b0, "R5", "tx_flag before stop", int'(tx_flag), 0);
    wait_n(per);
    chk(txd == 1'b1, req, "stop bit", int'(txd), 1);
    chk(tx_flag == 1'b1, "R5", "tx_flag during stop", int'(tx_flag), 1);
    wait_n(per / 2 + 2);
    if (poke) begin
      lows = 0;
      for (int k = 0; k < 3 * per; k++) begin
        @(negedge clk);
        if (txd == 1'b0) lows++;
      end
      chk(lows == 0, "R4", "low cycles after ignored write", lows, 0);
    end
    chk(tx_flag == 1'b1, "R5", "tx_flag held", int'(tx_flag), 1);
    clear_tx();
  endtask

  task automatic tx_width(input logic [1:0] m, input logic dbl, input int per, input string req);
    int cnt;
    int w;
    mode_sel = m; dbl_speed = dbl;
    write_byte(8'hFF, 1'b1);
    cnt = 0;
    while (txd === 1'b1 && cnt < 3 * per) begin
      @(negedge clk); cnt++;
    end
    w = 0;
    while (txd === 1'b0 && w < 3 * per) begin
      @(negedge clk); w++;
    end
    chk(w == per, req, "start bit width in cycles", w, per);
    wait_n(11 * per);
    clear_tx();
  endtask

  task automatic tx_off();
    int lows;
    mode_sel = 2'b00;
    write_byte(8'h00, 1'b0);
    lows = 0;
    for (int k = 0; k < 3 * VPER; k++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R1", "txd low cycles in mode 00", lows, 0);
    chk(tx_flag == 1'b0, "R1", "tx_flag in mode 00", int'(tx_flag), 0);
  endtask

  task automatic rx_frame(input logic [1:0] m, input logic dbl, input logic en, input logic sm2,
                          input logic [7:0] d, input logic b9, input int per, input string req);
    logic [10:0] bits;
    int n;
    logic fbit;
    mode_sel = m; dbl_speed = dbl; rx_en = en; mp_filter = sm2;
    if (m == 2'b01) begin
      bits = {1'b1, b9, d, 1'b0};
      n = 10;
    end else begin
      bits = {1'b1, b9, d, 1'b0};
      n = 11;
    end
    fbit = b9;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxd = bits[i];
      wait_n(per - 1);
    end
    @(negedge clk) rxd = 1'b1;
    wait_n(per);
    if (en && m != 2'b00 && !m_flag && (!sm2 || fbit)) begin
      m_data = d; m_b9 = fbit; m_flag = 1'b1;
    end
    chk(rx_flag == m_flag, req, "rx_flag", int'(rx_flag), int'(m_flag));
    chk(rx_data == m_data, req, "rx_data", int'(rx_data), int'(m_data));
    chk(rx_bit9 == m_b9, "R10", "rx_bit9", int'(rx_bit9), int'(m_b9));
    rx_en = 1'b1; mp_filter = 1'b0;
  endtask

  task automatic rx_glitch();
    mode_sel = 2'b01; dbl_speed = 1'b0;
    @(negedge clk) rxd = 1'b0;
    wait_n(14);
    @(negedge clk) rxd = 1'b1;
    wait_n(2 * VPER);
    chk(rx_flag == 1'b0, "R8", "rx_flag after start glitch", int'(rx_flag), 0);
    chk(rx_data == m_data, "R8", "rx_data after start glitch", int'(rx_data), int'(m_data));
    rx_frame(2'b01, 1'b0, 1'b1, 1'b0, 8'h5E, 1'b1, VPER, "R8");
    clear_rx();
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    chk(txd == 1'b1, "R4", "txd after reset", int'(txd), 1);
    chk(tx_flag == 1'b0, "R11", "tx_flag after reset", int'(tx_flag), 0);
    chk(rx_flag == 1'b0, "R11", "rx_flag after reset", int'(rx_flag), 0);
    chk(rx_data == 8'h00, "R11", "rx_data after reset", int'(rx_data), 0);

    tx_frame(2'b01, 1'b0, 8'hA5, 1'b0, VPER, 1'b0, "R2");
    tx_frame(2'b11, 1'b0, 8'h3C, 1'b1, VPER, 1'b1, "R3");
    tx_frame(2'b11, 1'b0, 8'h5A, 1'b0, VPER, 1'b0, "R3");
    tx_frame(2'b10, 1'b0, 8'h96, 1'b1, 64, 1'b0, "R6");
    tx_frame(2'b10, 1'b1, 8'h69, 1'b0, 32, 1'b0, "R6");
    tx_width(2'b10, 1'b0, 64, "R6");
    tx_width(2'b10, 1'b1, 32, "R6");
    tx_width(2'b11, 1'b0, VPER, "R7");
    tx_off();

    rx_frame(2'b01, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1, VPER, "R8");
    rx_frame(2'b01, 1'b0, 1'b1, 1'b0, 8'h17, 1'b1, VPER, "R9");
    clear_rx();
    rx_frame(2'b01, 1'b0, 1'b1, 1'b1, 8'h2D, 1'b0, VPER, "R9");
    rx_frame(2'b01, 1'b0, 1'b1, 1'b0, 8'h2D, 1'b0, VPER, "R10");
    clear_rx();
    rx_frame(2'b11, 1'b0, 1'b1, 1'b1, 8'h81, 1'b0, VPER, "R9");
    rx_frame(2'b11, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, VPER, "R9");
    clear_rx();
    rx_frame(2'b10, 1'b0, 1'b1, 1'b0, 8'hE4, 1'b0, 64, "R6");
    clear_rx();
    rx_frame(2'b10, 1'b1, 1'b1, 1'b0, 8'h4B, 1'b1, 32, "R6");
    clear_rx();
    rx_frame(2'b01, 1'b0, 1'b0, 1'b0, 8'h99, 1'b1, VPER, "R8");
    rx_frame(2'b00, 1'b0, 1'b1, 1'b0, 8'h77, 1'b1, VPER, "R1");
    rx_glitch();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule